// File: doc/BRIEF.md
# Sequenced SAR ADC Host Controller

This block is the host-side sequencer for a four-input multiplexed SAR converter. The converter is read after each conversion over a four-wire serial link. A sample-rate timer that counts system clocks sets the conversion period. On each timer tick the controller raises the convert strobe for a counted minimum width and then drops it. It then waits for the converter to pull its serial output low, which the converter does as a busy indicator at end of conversion. Once that low level is seen, the controller runs a burst of serial clocks. During the burst it shifts a 14-bit setup word out and a 16-bit sample in.

The converter applies a new setup word one conversion late, and each sample arrives two conversions after the sample was taken. After start-up, and again after any fault, the controller therefore treats its first two transfers as warm-up. It sends the setup word with the overwrite flag set and discards the returned data. From then on it resends the same word with the overwrite flag cleared, so the setup stays unchanged. Each kept sample leaves on a one-cycle valid strobe with the data and a channel tag that accounts for the two-conversion lag. If the busy indicator never arrives, the controller times out, raises an error flag and starts the warm-up again.

Top module: `sar_adc_host`

## Requirements
- R1: `adcCnv` rises once every `periodCycles` system clocks and stays high for exactly 2 clocks (the 10 ns minimum at an 8 ns clock, rounded up).
- R2: While `adcCnv` is high, `adcSck` and `adcDin` are both low. After each burst, at least 3 idle clocks pass before the next `adcCnv` rise.
- R3: Serial clocks start only after `adcSdo` is seen low while the controller is waiting for end of conversion. Each burst has exactly 17 `adcSck` pulses, each pulse 2 clocks high and 2 clocks low, and `adcSck` idles low.
- R4: `adcDin` carries the setup word MSB first. Each bit is stable across one of the first 14 `adcSck` rising edges, and the line changes only on falling edges. Bit layout: [13] overwrite, [12:10] input mode (parameter, default 3'b111), [9:7] last channel = 3, [6] bandwidth = 0, [5:3] reference = 3'b111, [2:1] sequencer = 2'b11, [0] readback = 0.
- R5: The converter presents the sample MSB first, one bit after each of the first 16 `adcSck` falling edges. The controller samples `adcSdo` while `adcSck` is high on pulses 2 to 17, so `resData` equals the 16 presented bits.
- R6: The first two bursts after reset or after a timeout send overwrite = 1 and produce no `resValid`. Every later burst sends overwrite = 0 and produces one `resValid`.
- R7: `resValid` is a one-clock pulse. Number the conversions from 0 after start-up. The sample read after conversion k (k >= 2) carries `resChan` = (k-2) mod 4.
- R8: If `adcSdo` is not low within `timeoutCycles` clocks after `adcCnv` falls, `errFlag` goes high, the controller returns to idle and restarts the warm-up (R6, R7 count anew). `errFlag` clears when the next burst completes.
- R9: After reset, `adcCnv`, `adcSck`, `adcDin`, `resValid` and `errFlag` are low.
- R10: A new `periodCycles` value takes effect for the following conversion periods without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodCycles | input | 16 | Conversion period in system clocks |
| timeoutCycles | input | 16 | Busy-indicator wait limit in system clocks |
| adcSdo | input | 1 | Converter serial data / busy indicator |
| adcCnv | output | 1 | Convert strobe |
| adcSck | output | 1 | Serial clock |
| adcDin | output | 1 | Setup word to converter |
| resValid | output | 1 | One-clock sample strobe |
| resData | output | 16 | Sample value |
| resChan | output | 2 | Input the sample belongs to |
| errFlag | output | 1 | Busy-indicator timeout seen |

## Verification
The risky internal state here is the warm-up count, the channel counter and the tag pipeline. A wrong value in any of them shows up at the ports on the next completed burst: a `resChan` that is off by one position, a sample released two bursts too early, or an overwrite bit that is wrong on `adcDin`. A wrong pulse or half-period count changes the number of `adcSck` edges within the same burst, and the 16-bit `resData` then comes out shifted. A broken timeout path appears as a stalled convert strobe or as an `errFlag` that never rises during a silent conversion.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNVHI,
    ST_WAITEOC,
    ST_XFER,
    ST_QUIET
  } hostStateT;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic convStart;
    logic xferStart;
    logic sckFall;
    logic sdoSample;
    logic xferDone;
    logic restart;
  } hostStrobeT;

endpackage

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
  import sar_host_pkg::*;
#(
  parameter int TIMER_W    = 16,
  parameter int CNV_HI_CYC = 2,
  parameter int QUIET_CYC  = 3,
  parameter int SCK_HALF   = 2,
  parameter int NPULSE     = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] periodCycles,
  input  logic [TIMER_W-1:0] timeoutCycles,
  input  logic               adcSdo,
  output logic               adcCnv,
  output logic               adcSck,
  output hostStrobeT         strb
);

  localparam int HOLD_MAX = (CNV_HI_CYC > QUIET_CYC) ? CNV_HI_CYC : QUIET_CYC;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
  localparam int HALF_W   = $clog2(SCK_HALF + 1);
  localparam int PULSE_W  = $clog2(NPULSE + 1);

  hostStateT          state;
  logic [TIMER_W-1:0] timerCnt;
  logic [TIMER_W-1:0] tmoCnt;
  logic [HOLD_W-1:0]  holdCnt;
  logic [HALF_W-1:0]  halfCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               tick;
  logic               endLow;
  logic               endHigh;
  logic               timeoutHit;

  // free-running sample-rate timer
  assign tick = (timerCnt >= periodCycles - TIMER_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || tick) timerCnt <= '0;
    else               timerCnt <= timerCnt + TIMER_W'(1);
  end

  assign endLow     = (state == ST_XFER) && !adcSck && (halfCnt == HALF_W'(SCK_HALF - 1));
  assign endHigh    = (state == ST_XFER) &&  adcSck && (halfCnt == HALF_W'(SCK_HALF - 1));
  assign timeoutHit = (state == ST_WAITEOC) && adcSdo && (tmoCnt >= timeoutCycles - TIMER_W'(1));

  always_comb begin
    strb           = '0;
    strb.convStart = (state == ST_IDLE) && tick;
    strb.xferStart = (state == ST_WAITEOC) && !adcSdo;
    strb.sckFall   = endHigh;
    strb.sdoSample = endHigh && (pulseCnt != '0);
    strb.xferDone  = endHigh && (pulseCnt == PULSE_W'(NPULSE - 1));
    strb.restart   = timeoutHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      adcCnv   <= 1'b0;
      adcSck   <= 1'b0;
      holdCnt  <= '0;
      halfCnt  <= '0;
      pulseCnt <= '0;
      tmoCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strb.convStart) begin
          state   <= ST_CNVHI;
          adcCnv  <= 1'b1;
          holdCnt <= '0;
        end
        ST_CNVHI: if (holdCnt == HOLD_W'(CNV_HI_CYC - 1)) begin
          state  <= ST_WAITEOC;
          adcCnv <= 1'b0;
          tmoCnt <= '0;
        end else begin
          holdCnt <= holdCnt + HOLD_W'(1);
        end
        ST_WAITEOC: if (strb.xferStart) begin
          state    <= ST_XFER;
          halfCnt  <= '0;
          pulseCnt <= '0;
        end else if (timeoutHit) begin
          state <= ST_IDLE;
        end else begin
          tmoCnt <= tmoCnt + TIMER_W'(1);
        end
        ST_XFER: if (endLow) begin
          adcSck  <= 1'b1;
          halfCnt <= '0;
        end else if (endHigh) begin
          adcSck   <= 1'b0;
          halfCnt  <= '0;
          pulseCnt <= pulseCnt + PULSE_W'(1);
          if (strb.xferDone) begin
            state   <= ST_QUIET;
            holdCnt <= '0;
          end
        end else begin
          halfCnt <= halfCnt + HALF_W'(1);
        end
        ST_QUIET: if (holdCnt == HOLD_W'(QUIET_CYC - 1)) state <= ST_IDLE;
                  else holdCnt <= holdCnt + HOLD_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cnv_width_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcCnv) |=> adcCnv);
  assert_sck_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    adcCnv |-> !adcSck);
  assert_sample_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.sdoSample |-> adcSck);
  assert_sck_after_eoc_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcSck) |-> (state == ST_XFER) && !adcCnv);

endmodule

// File: rtl/sar_host_dp.sv
module sar_host_dp
  import sar_host_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int CFG_W = 14,
  parameter int NCHAN = 4,
  parameter int LAG   = 2,
  parameter logic [CFG_W-2:0] CFG_BASE = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  hostStrobeT               strb,
  input  logic                     adcSdo,
  output logic                     adcDin,
  output logic                     resValid,
  output logic [RES_W-1:0]         resData,
  output logic [$clog2(NCHAN)-1:0] resChan,
  output logic                     errFlag
);

  localparam int CHAN_W = $clog2(NCHAN);
  localparam int WARM_W = $clog2(LAG + 1);

  logic [CFG_W-1:0]  dinSr;
  logic [RES_W-1:0]  resSr;
  logic [WARM_W-1:0] warmCnt;
  logic [CHAN_W-1:0] chanCnt;
  logic [CHAN_W-1:0] tagPipe [LAG+1];
  logic              warm;
  logic              clearSeq;

  assign warm     = (warmCnt == WARM_W'(LAG));
  assign clearSeq = !rstN || strb.restart;
  assign adcDin   = dinSr[CFG_W-1];

  // setup word: overwrite flag set until warm-up ends
  always_ff @(posedge clk) begin
    if (!rstN)              dinSr <= '0;
    else if (strb.xferStart) dinSr <= {!warm, CFG_BASE};
    else if (strb.sckFall)   dinSr <= {dinSr[CFG_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN)               resSr <= '0;
    else if (strb.sdoSample) resSr <= {resSr[RES_W-2:0], adcSdo};
  end

  always_ff @(posedge clk) begin
    if (clearSeq)                 chanCnt <= '0;
    else if (strb.convStart)      chanCnt <= (chanCnt == CHAN_W'(NCHAN - 1)) ? '0 : chanCnt + CHAN_W'(1);
  end

  // channel of each conversion travels alongside the converter pipeline
  always_ff @(posedge clk) begin
    if (clearSeq)            tagPipe[0] <= '0;
    else if (strb.convStart) tagPipe[0] <= chanCnt;
  end

  for (genvar i = 1; i <= LAG; i++) begin : gTag
    always_ff @(posedge clk) begin
      if (clearSeq)            tagPipe[i] <= '0;
      else if (strb.convStart) tagPipe[i] <= tagPipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (clearSeq)                    warmCnt <= '0;
    else if (strb.xferDone && !warm) warmCnt <= warmCnt + WARM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resData  <= '0;
      resChan  <= '0;
      errFlag  <= 1'b0;
    end else begin
      resValid <= strb.xferDone && warm;
      if (strb.xferDone && warm) begin
        resData <= {resSr[RES_W-2:0], adcSdo};
        resChan <= tagPipe[LAG];
      end
      if (strb.restart)       errFlag <= 1'b1;
      else if (strb.xferDone) errFlag <= 1'b0;
    end
  end

  assert_din_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.convStart |-> !adcDin);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
  assert_no_valid_on_fault_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> !resValid && errFlag);

endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
  import sar_host_pkg::*;
#(
  parameter int         TIMER_W       = 16,
  parameter int         CLK_PERIOD_NS = 8,
  parameter int         CNV_MIN_NS    = 10,
  parameter int         QUIET_PRE_NS  = 20,
  parameter int         QUIET_POST_NS = 10,
  parameter int         SCK_HALF      = 2,
  parameter logic [2:0] INPUT_MODE    = 3'b111,
  parameter logic [2:0] LAST_CHAN     = 3'd3,
  parameter logic       BW_FULL       = 1'b0,
  parameter logic [2:0] REF_SEL       = 3'b111,
  parameter logic [1:0] SEQ_MODE      = 2'b11,
  parameter logic       READBACK      = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] periodCycles,
  input  logic [TIMER_W-1:0] timeoutCycles,
  input  logic               adcSdo,
  output logic               adcCnv,
  output logic               adcSck,
  output logic               adcDin,
  output logic               resValid,
  output logic [15:0]        resData,
  output logic [1:0]         resChan,
  output logic               errFlag
);

  localparam int CNV_NS     = (CNV_MIN_NS > QUIET_POST_NS) ? CNV_MIN_NS : QUIET_POST_NS;
  localparam int CNV_HI_CYC = (CNV_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int QUIET_CYC  = (QUIET_PRE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int NPULSE     = READBACK ? 31 : 17;
  localparam int NCHAN      = int'(LAST_CHAN) + 1;
  localparam logic [12:0] CFG_BASE = {INPUT_MODE, LAST_CHAN, BW_FULL, REF_SEL, SEQ_MODE, READBACK};

  hostStrobeT strb;

  sar_host_ctrl #(
    .TIMER_W(TIMER_W), .CNV_HI_CYC(CNV_HI_CYC), .QUIET_CYC(QUIET_CYC),
    .SCK_HALF(SCK_HALF), .NPULSE(NPULSE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .periodCycles(periodCycles), .timeoutCycles(timeoutCycles),
    .adcSdo(adcSdo), .adcCnv(adcCnv), .adcSck(adcSck), .strb(strb)
  );

  sar_host_dp #(
    .RES_W(16), .CFG_W(14), .NCHAN(NCHAN), .LAG(2), .CFG_BASE(CFG_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .adcSdo(adcSdo), .adcDin(adcDin),
    .resValid(resValid), .resData(resData), .resChan(resChan), .errFlag(errFlag)
  );

endmodule

// File: tb/sar_adc_host_bench.sv
module sar_adc_host_bench;

  localparam int EOC_CYC = 40;
  localparam logic [12:0] CFG_LOW = {3'b111, 3'd3, 1'b0, 3'b111, 2'b11, 1'b0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] periodCycles = 16'd200;
  logic [15:0] timeoutCycles = 16'd100;
  logic        adcSdo = 1'b1;
  logic        adcCnv, adcSck, adcDin, resValid, errFlag;
  logic [15:0] resData;
  logic [1:0]  resChan;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sar_adc_host u_sar_adc_host (
    .clk(clk), .rstN(rstN), .periodCycles(periodCycles), .timeoutCycles(timeoutCycles),
    .adcSdo(adcSdo), .adcCnv(adcCnv), .adcSck(adcSck), .adcDin(adcDin),
    .resValid(resValid), .resData(resData), .resChan(resChan), .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wordFor(input int n);
    if (n == 5) return 16'hFFFF;
    if (n == 6) return 16'h0000;
    return 16'(n * 16'h1357 + 16'h8001);
  endfunction

  // converter model, evaluated on the falling clock edge
  logic prevCnv = 1'b0, prevSck = 1'b0, prevErr = 1'b0;
  bit   inXfer = 0, mutePending = 0, muteNow = 0, skipInterval = 1;
  int   kSince = 0, kGlobal = 0, curK = 0, lastK = 0;
  int   eocCnt = 0, fallN = 0, riseN = 0, hiLen = 0, sinceRise = 0, idleLen = 100;
  int   expValid = 0, gotValid = 0, errSeen = 0, convTotal = 0;
  logic [15:0] word = '0, lastWord = '0;
  logic [13:0] cfgCap = '0;

  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      sinceRise++;
      // results
      if (resValid) begin
        gotValid++;
        check(lastK >= 2, "R6 valid during warm-up", lastK, 2);
        check(resData == lastWord, "R5 data", resData, lastWord);
        check(resChan == 2'((lastK - 2) % 4), "R7 channel tag", resChan, (lastK - 2) % 4);
      end
      if (errFlag && !prevErr) begin
        errSeen++;
        check(muteNow, "R8 error only on silent conversion", 0, 1);
        kSince = 0;
        muteNow = 0;
      end
      if (adcCnv) begin
        check(!adcSck && !adcDin, "R2 lines quiet during CNV", {adcSck, adcDin}, 0);
        hiLen++;
      end
      if (!adcCnv && prevCnv) check(hiLen == 2, "R1 CNV width", hiLen, 2);
      if (!adcCnv && !adcSck && !inXfer) idleLen++;
      if (adcCnv && !prevCnv) begin
        check(idleLen >= 3, "R2 idle before CNV", idleLen, 3);
        if (!skipInterval) check(sinceRise == int'(periodCycles), "R1 R10 period", sinceRise, periodCycles);
        skipInterval = 0;
        sinceRise = 0;
        hiLen = 1;
        curK = kSince;
        kSince++;
        kGlobal++;
        convTotal++;
        eocCnt = EOC_CYC;
        if (mutePending) begin muteNow = 1; mutePending = 0; end
      end
      if (adcSck && !prevSck && !inXfer) check(0, "R3 SCK before busy low", 1, 0);
      if (eocCnt > 0) begin
        eocCnt--;
        if (eocCnt == 0 && !muteNow) begin
          check(!adcCnv, "R3 CNV low at EOC", adcCnv, 0);
          adcSdo = 1'b0;
          inXfer = 1;
          fallN = 0;
          riseN = 0;
          idleLen = 0;
          word = wordFor(kGlobal);
          lastWord = word;
          lastK = curK;
        end
      end
      if (inXfer) begin
        if (adcSck && !prevSck) begin
          riseN++;
          if (riseN <= 14) cfgCap = {cfgCap[12:0], adcDin};
        end
        if (!adcSck && prevSck) begin
          fallN++;
          if (fallN <= 16) adcSdo = word[16 - fallN];
          if (fallN == 17) begin
            adcSdo = 1'b1;
            inXfer = 0;
            idleLen = 0;
            check(riseN == 17, "R3 pulse count", riseN, 17);
            check(cfgCap == {(lastK < 2), CFG_LOW}, "R4 R6 setup word", cfgCap, {(lastK < 2), CFG_LOW});
            if (lastK >= 2) expValid++;
          end
        end
      end
    end
    prevCnv = adcCnv;
    prevSck = adcSck;
    prevErr = errFlag;
  end

  // SCK shape: each level lasts 2 clocks inside a burst
  int levelLen = 0;
  logic prevSckShape = 1'b0;
  always @(negedge clk) begin
    if (rstN && inXfer && fallN < 17) begin
      if (adcSck != prevSckShape) begin
        if (fallN > 0 || adcSck == 1'b0) check(levelLen == 2, "R3 SCK half period", levelLen, 2);
        levelLen = 1;
      end else levelLen++;
    end else levelLen = 2;
    prevSckShape = adcSck;
  end

  task automatic waitConv(input int n);
    int target = convTotal + n;
    while (convTotal < target) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check({adcCnv, adcSck, adcDin, resValid, errFlag} == 5'b0, "R9 reset outputs",
          {adcCnv, adcSck, adcDin, resValid, errFlag}, 0);
    rstN = 1'b1;
    waitConv(14);
    // R8: one silent conversion
    mutePending = 1;
    waitConv(7);
    check(errSeen == 1, "R8 timeout flagged", errSeen, 1);
    check(!errFlag, "R8 flag cleared by next burst", errFlag, 0);
    // R10: new period
    @(negedge clk);
    periodCycles = 16'd260;
    skipInterval = 1;
    waitConv(9);
    repeat (300) @(negedge clk);
    check(gotValid == expValid, "R6 R7 result count", gotValid, expValid);
    check(gotValid >= 20, "R7 enough results", gotValid, 20);
    finishRun();
  end

endmodule